// File: doc/BRIEF.md
# Main-CPU Bus Address Decoder

This block sits between a 24-bit main-CPU bus and the memories and peripherals behind it. Each access is byte- or word-wide. Its address is classified in the same cycle into one of seven data targets: cartridge ROM, mirrored 64 KB work RAM, the video controller ports, the sound data port, the I/O port window, the co-processor memory window and an optional save RAM. The block produces one chip select, a translated target address, byte-lane enables and write data. It returns the read data placed in the right lane. An access that matches no target is dropped and raises a one-cycle error strobe.

Two control registers sit inside the decoder. They hold the co-processor bus-request bit and the co-processor reset bit. A four-state machine tracks the two bits:

- `CP_HELD`: reset asserted, bus not requested.
- `CP_HELD_GRANTED`: reset asserted, bus requested.
- `CP_RUNNING`: reset released, bus not requested.
- `CP_GRANTED`: reset released, bus requested.

The machine has two kinds of transition:

- `grant_write` moves along the request axis. It is caused by a write to the bus-request register.
- `reset_write` moves along the reset axis. It is caused by a write to the reset register. A write that asserts reset also fires a one-cycle soft-reset pulse.

A write of the same value leaves the state where it is. The bus-request register reads back 0 only in `CP_GRANTED`.

Top module: `main_bus_decoder`

## Requirements
- R1: Only address bits 23:0 are decoded; higher bits have no effect. Word accesses ignore address bit 0.
- R2: `tgt_sel` bit positions are: 0 ROM, 1 work RAM, 2 video, 3 sound, 4 I/O, 5 co-processor, 6 save RAM. A valid access to a data target sets exactly that bit, combinationally, in the same cycle. `tgt_we` is high only for such an access that is a write. With `req_valid` low, no select is set.
- R3: Reads below 0x400000 that save RAM does not claim select ROM, and `tgt_addr` is the address with bit 0 cleared. A word read returns `tgt_rdata` unchanged, with the even byte in bits 15:8. A byte read returns bits 15:8 for an even address and bits 7:0 for an odd address, in `req_rdata[7:0]`, with the upper byte zero. Writes below 0x400000 outside save RAM are unmapped.
- R4: Addresses at or above 0xE00000 select work RAM with `tgt_addr` = {8'h00, addr[15:1], 0}, so the RAM is mirrored. `tgt_be` is 2'b11 for a word access. For a byte access it is 2'b10 at an even address and 2'b01 at an odd address. Byte write data appears in both halves of `tgt_wdata`. Byte reads use the R3 lane rule.
- R5: 0xC00000 to 0xC0000F selects video with `tgt_addr` = {addr[3:1], 0}. A byte write sends `tgt_be` = 2'b11 with the byte copied into both halves. Byte reads use the R3 lane rule.
- R6: Byte writes to odd addresses 0xC00011 to 0xC00017 select the sound port with `tgt_addr` = addr[2:0]. Reads there, and even addresses there, are unmapped.
- R7: Byte accesses to 0xA10000 to 0xA1001F select I/O with `tgt_addr` = addr[4:0]. Byte accesses whose top address byte is 0xA0 select the co-processor with `tgt_addr` = addr[14:0]. Byte targets use `tgt_be` = 2'b01 and return their byte in `req_rdata[7:0]` with the upper byte zero. Word accesses to these two windows are unmapped.
- R8: A write to 0xA11100 sets `cp_busreq` from data bit 8 (word) or bit 0 (byte), starting the next cycle. A read there returns 0 only when the request is held and the co-processor is out of reset, otherwise 1. The bit appears in bit 8 for a word read and in bit 0 for a byte read.
- R9: A write to 0xA11200 with 0 in bit 8 (word) or bit 0 (byte) sets `cp_reset` next cycle and pulses `cp_soft_rst` for exactly that cycle. A write with 1 there releases `cp_reset`. Reads of 0xA11200 are unmapped.
- R10: With `sram_en` high, byte accesses with `sram_start` ≤ addr < `sram_end` select save RAM. `tgt_addr` is (addr − `sram_start`), shifted right by one when `sram_alt` is high. Any save-RAM write sets `sram_dirty` from the next cycle until reset.
- R11: Overlaps resolve in this order: work RAM, co-processor window, I/O, control registers, video, sound, save RAM, ROM.
- R12: An unmapped access sets no select and no write enable, and changes no control state. A word read returns 0x7DCD and a byte read returns 0x007D. `bus_err` is high for exactly the next cycle.
- R13: After reset, `bus_err`, `sram_dirty`, `cp_busreq` and `cp_soft_rst` are 0, and `cp_reset` is 1 (state `CP_HELD`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | IN_AW (32) | Byte address; bits 23:0 decoded |
| req_wdata | input | 16 | Write data; a byte is carried in bits 7:0 |
| req_rdata | output | 16 | Read data returned to the CPU |
| sram_en | input | 1 | Save-RAM window enable |
| sram_alt | input | 1 | Every-other-byte indexing for save RAM |
| sram_start | input | 24 | First save-RAM address |
| sram_end | input | 24 | Save-RAM end address (exclusive) |
| tgt_sel | output | 7 | One-hot target select |
| tgt_addr | output | 24 | Translated target address |
| tgt_we | output | 1 | Target write strobe |
| tgt_be | output | 2 | Lane enables (bit 1 = even/high byte) |
| tgt_wdata | output | 16 | Target write data |
| tgt_rdata | input | 16 | Read data from the selected target |
| bus_err | output | 1 | One-cycle strobe after an unmapped access |
| sram_dirty | output | 1 | Sticky save-RAM-written flag |
| cp_busreq | output | 1 | Co-processor bus request held |
| cp_reset | output | 1 | Co-processor held in reset |
| cp_soft_rst | output | 1 | One-cycle co-processor soft-reset pulse |

## Verification
A wrong control-machine state shows at `cp_busreq` or `cp_reset` on the cycle after the write that caused it. It shows again on the next status read of 0xA11100, as a flipped bit 0 or bit 8. A misclassified address shows in the same cycle as a wrong or missing select, a wrong translated address or the wrong read-data lane. It also shows one cycle later as a spurious or missing `bus_err`. A save-RAM write that is lost shows as `sram_dirty` staying low on the following cycle.

// File: rtl/busdec_pkg.sv
`timescale 1ns/1ps
package busdec_pkg;
    localparam int DEC_W   = 24;
    localparam int DW      = 16;
    localparam int NSEL    = 7;
    localparam int VID_SPW = 4;

    localparam logic [DEC_W-1:0] ROM_END     = 24'h400000;
    localparam logic [DEC_W-1:0] WRAM_BASE   = 24'hE00000;
    localparam logic [7:0]       COP_PAGE    = 8'hA0;
    localparam logic [DEC_W-1:0] IO_LO       = 24'hA10000;
    localparam logic [DEC_W-1:0] IO_HI       = 24'hA1001F;
    localparam logic [DEC_W-1:0] BUSREQ_ADDR = 24'hA11100;
    localparam logic [DEC_W-1:0] CPRST_ADDR  = 24'hA11200;
    localparam logic [DEC_W-1:0] VID_BASE    = 24'hC00000;
    localparam logic [DEC_W-1:0] SND_LO      = 24'hC00011;
    localparam logic [DEC_W-1:0] SND_HI      = 24'hC00017;
    localparam logic [DW-1:0]    MISS_WORD   = 16'h7DCD;
    localparam logic [DW-1:0]    MISS_BYTE   = 16'h007D;

    typedef enum logic [3:0] {
        TG_ROM    = 4'd0,
        TG_WRAM   = 4'd1,
        TG_VIDEO  = 4'd2,
        TG_SOUND  = 4'd3,
        TG_IO     = 4'd4,
        TG_COP    = 4'd5,
        TG_SRAM   = 4'd6,
        TG_BUSREQ = 4'd7,
        TG_CPRST  = 4'd8,
        TG_NONE   = 4'd9
    } tgt_e;

    typedef enum logic [1:0] {
        CP_HELD         = 2'd0,
        CP_HELD_GRANTED = 2'd1,
        CP_RUNNING      = 2'd2,
        CP_GRANTED      = 2'd3
    } cp_state_e;
endpackage

// File: rtl/busdec_classify.sv
`timescale 1ns/1ps
module busdec_classify
    import busdec_pkg::*;
(
    input  logic [DEC_W-1:0] addr,
    input  logic             wr,
    input  logic             word,
    input  logic             sram_en,
    input  logic [DEC_W-1:0] sram_start,
    input  logic [DEC_W-1:0] sram_end,
    output tgt_e             cls
);
    logic byte_acc;
    logic hit_wram, hit_cop, hit_io, hit_br, hit_rs;
    logic hit_vid, hit_snd, hit_sram, hit_rom;

    assign byte_acc = !word;
    assign hit_wram = addr >= WRAM_BASE;
    assign hit_cop  = byte_acc && (addr[DEC_W-1:DEC_W-8] == COP_PAGE);
    assign hit_io   = byte_acc && (addr >= IO_LO) && (addr <= IO_HI);
    assign hit_br   = addr == BUSREQ_ADDR;
    assign hit_rs   = wr && (addr == CPRST_ADDR);
    assign hit_vid  = addr[DEC_W-1:VID_SPW] == VID_BASE[DEC_W-1:VID_SPW];
    assign hit_snd  = wr && byte_acc && addr[0] && (addr >= SND_LO) && (addr <= SND_HI);
    assign hit_sram = sram_en && byte_acc && (addr >= sram_start) && (addr < sram_end);
    assign hit_rom  = !wr && (addr < ROM_END);

    // Fixed priority chain, highest first.
    always_comb begin
        if (hit_wram)      cls = TG_WRAM;
        else if (hit_cop)  cls = TG_COP;
        else if (hit_io)   cls = TG_IO;
        else if (hit_br)   cls = TG_BUSREQ;
        else if (hit_rs)   cls = TG_CPRST;
        else if (hit_vid)  cls = TG_VIDEO;
        else if (hit_snd)  cls = TG_SOUND;
        else if (hit_sram) cls = TG_SRAM;
        else if (hit_rom)  cls = TG_ROM;
        else               cls = TG_NONE;
    end
endmodule

// File: rtl/busdec_lanes.sv
`timescale 1ns/1ps
module busdec_lanes
    import busdec_pkg::*;
(
    input  tgt_e             cls,
    input  logic [DEC_W-1:0] addr,
    input  logic             word,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    tgt_rdata,
    input  logic [DEC_W-1:0] sram_start,
    input  logic             sram_alt,
    input  logic             bus_busy,
    output logic [DEC_W-1:0] tgt_addr,
    output logic [1:0]       tgt_be,
    output logic [DW-1:0]    tgt_wdata,
    output logic [DW-1:0]    rdata
);
    logic [DEC_W-1:0] sram_off;
    logic [7:0]       lane_byte;

    assign sram_off  = addr - sram_start;
    assign lane_byte = addr[0] ? tgt_rdata[7:0] : tgt_rdata[15:8];
    assign tgt_wdata = word ? wdata : {wdata[7:0], wdata[7:0]};

    always_comb begin
        tgt_addr = '0;
        tgt_be   = 2'b00;
        rdata    = word ? MISS_WORD : MISS_BYTE;
        unique case (cls)
            TG_ROM, TG_WRAM, TG_VIDEO: begin
                if (cls == TG_ROM)
                    tgt_addr = {addr[DEC_W-1:1], 1'b0};
                else if (cls == TG_WRAM)
                    tgt_addr = DEC_W'({addr[15:1], 1'b0});
                else
                    tgt_addr = DEC_W'({addr[VID_SPW-1:1], 1'b0});
                if (word || cls == TG_VIDEO) tgt_be = 2'b11;
                else                         tgt_be = addr[0] ? 2'b01 : 2'b10;
                rdata = word ? tgt_rdata : {8'h00, lane_byte};
            end
            TG_SOUND: begin
                tgt_addr = DEC_W'(addr[2:0]);
                tgt_be   = 2'b01;
            end
            TG_IO: begin
                tgt_addr = DEC_W'(addr[4:0]);
                tgt_be   = 2'b01;
                rdata    = {8'h00, tgt_rdata[7:0]};
            end
            TG_COP: begin
                tgt_addr = DEC_W'(addr[14:0]);
                tgt_be   = 2'b01;
                rdata    = {8'h00, tgt_rdata[7:0]};
            end
            TG_SRAM: begin
                tgt_addr = sram_alt ? {1'b0, sram_off[DEC_W-1:1]} : sram_off;
                tgt_be   = 2'b01;
                rdata    = {8'h00, tgt_rdata[7:0]};
            end
            TG_BUSREQ: rdata = word ? {7'h00, bus_busy, 8'h00} : {15'h0000, bus_busy};
            TG_CPRST, TG_NONE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/busdec_cpctl.sv
`timescale 1ns/1ps
module busdec_cpctl
    import busdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_wr,
    input  logic rs_wr,
    input  logic ctl_bit,
    output logic cp_busreq,
    output logic cp_reset,
    output logic soft_rst,
    output logic bus_busy
);
    cp_state_e st_q, st_d;
    logic      held, grant;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CP_HELD;
            soft_rst <= 1'b0;
        end else begin
            st_q     <= st_d;
            soft_rst <= rs_wr && !ctl_bit;
        end
    end

    // Next state: grant_write moves the request axis, reset_write the reset axis.
    always_comb begin
        held  = 1'b1;
        grant = 1'b0;
        unique case (st_q)
            CP_HELD:         begin held = 1'b1; grant = 1'b0; end
            CP_HELD_GRANTED: begin held = 1'b1; grant = 1'b1; end
            CP_RUNNING:      begin held = 1'b0; grant = 1'b0; end
            CP_GRANTED:      begin held = 1'b0; grant = 1'b1; end
            default: ;
        endcase
        if (br_wr) grant = ctl_bit;
        if (rs_wr) held  = !ctl_bit;
        if (held) st_d = grant ? CP_HELD_GRANTED : CP_HELD;
        else      st_d = grant ? CP_GRANTED : CP_RUNNING;
    end

    // Outputs from state.
    always_comb begin
        cp_busreq = 1'b0;
        cp_reset  = 1'b1;
        bus_busy  = 1'b1;
        unique case (st_q)
            CP_HELD:         begin cp_busreq = 1'b0; cp_reset = 1'b1; end
            CP_HELD_GRANTED: begin cp_busreq = 1'b1; cp_reset = 1'b1; end
            CP_RUNNING:      begin cp_busreq = 1'b0; cp_reset = 1'b0; end
            CP_GRANTED:      begin cp_busreq = 1'b1; cp_reset = 1'b0; bus_busy = 1'b0; end
            default: ;
        endcase
    end

    a_r8_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
        br_wr |=> (cp_busreq == $past(ctl_bit)));
    a_r9_soft_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_wr && !ctl_bit) |=> (soft_rst && cp_reset));
    a_r9_soft_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> cp_reset);
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_wr && ctl_bit) |=> !cp_reset);
endmodule

// File: rtl/main_bus_decoder.sv
`timescale 1ns/1ps
module main_bus_decoder
    import busdec_pkg::*;
#(
    parameter int IN_AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_word,
    input  logic [IN_AW-1:0] req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    req_rdata,
    input  logic             sram_en,
    input  logic             sram_alt,
    input  logic [DEC_W-1:0] sram_start,
    input  logic [DEC_W-1:0] sram_end,
    output logic [NSEL-1:0]  tgt_sel,
    output logic [DEC_W-1:0] tgt_addr,
    output logic             tgt_we,
    output logic [1:0]       tgt_be,
    output logic [DW-1:0]    tgt_wdata,
    input  logic [DW-1:0]    tgt_rdata,
    output logic             bus_err,
    output logic             sram_dirty,
    output logic             cp_busreq,
    output logic             cp_reset,
    output logic             cp_soft_rst
);
    logic [DEC_W-1:0] addr_eff;
    logic             unused_hi;
    tgt_e             cls;
    logic             ctl_bit, br_wr, rs_wr, bus_busy;

    assign unused_hi = ^req_addr[IN_AW-1:DEC_W];
    assign addr_eff  = req_word ? {req_addr[DEC_W-1:1], 1'b0} : req_addr[DEC_W-1:0];
    assign ctl_bit   = req_word ? req_wdata[8] : req_wdata[0];
    assign br_wr     = req_valid && req_write && (cls == TG_BUSREQ);
    assign rs_wr     = req_valid && req_write && (cls == TG_CPRST);

    busdec_classify u_cls (
        .addr(addr_eff), .wr(req_write), .word(req_word),
        .sram_en(sram_en), .sram_start(sram_start), .sram_end(sram_end),
        .cls(cls)
    );

    busdec_lanes u_lanes (
        .cls(cls), .addr(addr_eff), .word(req_word), .wdata(req_wdata),
        .tgt_rdata(tgt_rdata), .sram_start(sram_start), .sram_alt(sram_alt),
        .bus_busy(bus_busy), .tgt_addr(tgt_addr), .tgt_be(tgt_be),
        .tgt_wdata(tgt_wdata), .rdata(req_rdata)
    );

    busdec_cpctl u_cp (
        .clk(clk), .rst_n(rst_n), .br_wr(br_wr), .rs_wr(rs_wr), .ctl_bit(ctl_bit),
        .cp_busreq(cp_busreq), .cp_reset(cp_reset), .soft_rst(cp_soft_rst),
        .bus_busy(bus_busy)
    );

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_sel
        assign tgt_sel[gi] = req_valid && (cls == tgt_e'(4'(gi)));
    end

    assign tgt_we = req_valid && req_write && (cls <= TG_SRAM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err    <= 1'b0;
            sram_dirty <= 1'b0;
        end else begin
            bus_err <= req_valid && (cls == TG_NONE);
            if (req_valid && req_write && (cls == TG_SRAM)) sram_dirty <= 1'b1;
        end
    end

    a_r12_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tgt_we && (tgt_sel == '0) && !(cls == TG_BUSREQ) && !(cls == TG_CPRST)) |=> bus_err);
    a_r10_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dirty |=> sram_dirty);
    a_r10_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_we && tgt_sel[TG_SRAM]) |=> sram_dirty);
    a_r2_we_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> ($onehot(tgt_sel) && req_write));
    a_r12_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bus_busy && tgt_sel == '0 && !req_write && !req_word && cls == TG_NONE)
        |-> (req_rdata == MISS_BYTE));
endmodule

// File: tb/tb_main_bus_decoder.sv
`timescale 1ns/1ps
module tb_main_bus_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0, req_rdata;
    logic        sram_en = 1'b0, sram_alt = 1'b0;
    logic [23:0] sram_start = '0, sram_end = '0;
    logic [6:0]  tgt_sel;
    logic [23:0] tgt_addr;
    logic        tgt_we;
    logic [1:0]  tgt_be;
    logic [15:0] tgt_wdata, tgt_rdata;
    logic        bus_err, sram_dirty, cp_busreq, cp_reset, cp_soft_rst;

    int n_chk = 0, n_bad = 0;
    logic m_grant = 1'b0, m_held = 1'b1, m_dirty = 1'b0;
    logic [15:0] wram_m [256];
    logic [7:0]  sram_m [256];

    always #2.5 clk = ~clk;

    main_bus_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .sram_en(sram_en), .sram_alt(sram_alt),
        .sram_start(sram_start), .sram_end(sram_end), .tgt_sel(tgt_sel),
        .tgt_addr(tgt_addr), .tgt_we(tgt_we), .tgt_be(tgt_be),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .bus_err(bus_err),
        .sram_dirty(sram_dirty), .cp_busreq(cp_busreq), .cp_reset(cp_reset),
        .cp_soft_rst(cp_soft_rst)
    );

    function automatic logic [15:0] stub(input logic [3:0] c, input logic [23:0] ta);
        case (c)
            4'd0: return ta[16:1] ^ 16'hA55A;
            4'd1: return wram_m[ta[8:1]];
            4'd2: return {4'hC, ta[3:0], 8'h3C};
            4'd4: return {8'hEE, ta[7:0] ^ 8'h90};
            4'd5: return {8'hEE, ta[7:0] ^ 8'h21};
            4'd6: return {8'hEE, sram_m[ta[7:0]]};
            default: return 16'h0000;
        endcase
    endfunction

    always_comb begin
        tgt_rdata = 16'h0000;
        for (int i = 0; i < 7; i++)
            if (tgt_sel[i]) tgt_rdata = stub(4'(i), tgt_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                wram_m[i] <= 16'(i * 257) ^ 16'h1357;
                sram_m[i] <= 8'(i) ^ 8'h6C;
            end
        end else if (tgt_we && tgt_sel[1]) begin
            if (tgt_be[1]) wram_m[tgt_addr[8:1]][15:8] <= tgt_wdata[15:8];
            if (tgt_be[0]) wram_m[tgt_addr[8:1]][7:0]  <= tgt_wdata[7:0];
        end else if (tgt_we && tgt_sel[6]) begin
            sram_m[tgt_addr[7:0]] <= tgt_wdata[7:0];
        end
    end

    // Class codes: 0..6 data targets, 7 bus request, 8 reset reg, 9 unmapped.
    function automatic logic [3:0] m_cls(input logic [23:0] a, input logic wr, input logic wd);
        if (a >= 24'hE00000) return 4'd1;
        if (!wd && a[23:16] == 8'hA0) return 4'd5;
        if (!wd && a >= 24'hA10000 && a <= 24'hA1001F) return 4'd4;
        if (a == 24'hA11100) return 4'd7;
        if (wr && a == 24'hA11200) return 4'd8;
        if (a[23:4] == 20'hC0000) return 4'd2;
        if (wr && !wd && a[0] && a >= 24'hC00011 && a <= 24'hC00017) return 4'd3;
        if (sram_en && !wd && a >= sram_start && a < sram_end) return 4'd6;
        if (!wr && a < 24'h400000) return 4'd0;
        return 4'd9;
    endfunction

    function automatic logic [23:0] m_taddr(input logic [3:0] c, input logic [23:0] a);
        logic [23:0] off;
        off = a - sram_start;
        case (c)
            4'd0: return {a[23:1], 1'b0};
            4'd1: return {8'h00, a[15:1], 1'b0};
            4'd2: return {20'h0, a[3:1], 1'b0};
            4'd3: return {21'h0, a[2:0]};
            4'd4: return {19'h0, a[4:0]};
            4'd5: return {9'h0, a[14:0]};
            4'd6: return sram_alt ? (off >> 1) : off;
            default: return 24'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4, 4'd5: return "R7";
            4'd6: return "R10";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, got, exp);
        end
    endtask

    task automatic acc(input logic [31:0] a, input logic wr, input logic wd,
                       input logic [15:0] d, input string rq);
        logic [23:0] ea, xa;
        logic [3:0]  c;
        logic [1:0]  xbe;
        logic [15:0] raw, xr;
        logic        cb, stat;
        string       t;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        ea = wd ? {a[23:1], 1'b0} : a[23:0];
        c  = m_cls(ea, wr, wd);
        t  = (rq == "") ? tag_of(c) : rq;
        xa = m_taddr(c, ea);
        cb = wd ? d[8] : d[0];
        #1;
        chk(t, "sel", 32'(tgt_sel), (c < 4'd7) ? 32'(7'(1) << c) : 32'd0);
        if (c < 4'd7) chk(t, "taddr", 32'(tgt_addr), 32'(xa));
        if (wr) begin
            chk(t, "we", 32'(tgt_we), 32'(c < 4'd7));
            if (c < 4'd7) begin
                if (c <= 4'd1) xbe = wd ? 2'b11 : (ea[0] ? 2'b01 : 2'b10);
                else if (c == 4'd2) xbe = 2'b11;
                else xbe = 2'b01;
                chk(t, "be", 32'(tgt_be), 32'(xbe));
                chk(t, "wdata", 32'(tgt_wdata), wd ? 32'(d) : 32'({d[7:0], d[7:0]}));
            end
        end else begin
            raw = stub(c, xa);
            stat = !(m_grant && !m_held);
            if (c <= 4'd2) xr = wd ? raw : {8'h00, ea[0] ? raw[7:0] : raw[15:8]};
            else if (c < 4'd7) xr = {8'h00, raw[7:0]};
            else if (c == 4'd7) xr = wd ? {7'h0, stat, 8'h00} : {15'h0, stat};
            else xr = wd ? 16'h7DCD : 16'h007D;
            chk(t, "rdata", 32'(req_rdata), 32'(xr));
        end
        @(posedge clk);
        if (wr && c == 4'd7) m_grant = cb;
        if (wr && c == 4'd8) m_held = !cb;
        if (wr && c == 4'd6) m_dirty = 1'b1;
        #1;
        chk((rq == "") ? "R12" : rq, "err", 32'(bus_err), 32'(c == 4'd9));
        chk("R9", "soft", 32'(cp_soft_rst), 32'(wr && c == 4'd8 && !cb));
        chk("R8", "busreq", 32'(cp_busreq), 32'(m_grant));
        chk("R9", "reset", 32'(cp_reset), 32'(m_held));
        chk("R10", "dirty", 32'(sram_dirty), 32'(m_dirty));
        req_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] bases [13];
        logic [31:0] r, s;
        bases = '{24'h000000, 24'h3FFF00, 24'hE00000, 24'hFFFF00, 24'hC00000,
                  24'hC00010, 24'hA10000, 24'hA00000, 24'hA11100, 24'hA11200,
                  24'h300000, 24'h500000, 24'h400000};
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13", "err", 32'(bus_err), 32'd0);
        chk("R13", "dirty", 32'(sram_dirty), 32'd0);
        chk("R13", "busreq", 32'(cp_busreq), 32'd0);
        chk("R13", "reset", 32'(cp_reset), 32'd1);
        chk("R13", "soft", 32'(cp_soft_rst), 32'd0);
        chk("R2", "idle sel", 32'(tgt_sel), 32'd0);

        acc(32'hFFE01234, 1'b0, 1'b1, 16'h0, "R1");      // high bits ignored
        acc(32'h00E01235, 1'b0, 1'b1, 16'h0, "R1");      // word ignores bit 0
        acc(32'h00000101, 1'b0, 1'b0, 16'h0, "R3");
        acc(32'h00000100, 1'b0, 1'b0, 16'h0, "R3");
        acc(32'h00000100, 1'b1, 1'b1, 16'h1111, "R3");   // ROM write unmapped
        acc(32'h00E01235, 1'b1, 1'b0, 16'h00A7, "R4");
        acc(32'h00FF1235, 1'b0, 1'b0, 16'h0, "R4");      // mirror read back
        acc(32'h00C00003, 1'b1, 1'b0, 16'h005A, "R5");
        acc(32'h00C00005, 1'b0, 1'b0, 16'h0, "R5");
        acc(32'h00C00011, 1'b1, 1'b0, 16'h0033, "R6");
        acc(32'h00C00012, 1'b1, 1'b0, 16'h0033, "R6");
        acc(32'h00C00011, 1'b0, 1'b0, 16'h0, "R6");
        acc(32'h00A10003, 1'b0, 1'b0, 16'h0, "R7");
        acc(32'h00A07FFF, 1'b0, 1'b0, 16'h0, "R7");
        acc(32'h00A00010, 1'b0, 1'b1, 16'h0, "R7");
        acc(32'h00A11100, 1'b1, 1'b0, 16'h0001, "R8");
        acc(32'h00A11100, 1'b0, 1'b0, 16'h0, "R8");
        acc(32'h00A11200, 1'b1, 1'b0, 16'h0001, "R9");
        acc(32'h00A11100, 1'b0, 1'b0, 16'h0, "R8");
        acc(32'h00A11100, 1'b0, 1'b1, 16'h0, "R8");
        acc(32'h00A11100, 1'b1, 1'b1, 16'h0000, "R8");
        acc(32'h00A11100, 1'b0, 1'b1, 16'h0, "R8");
        acc(32'h00A11200, 1'b1, 1'b1, 16'h0000, "R9");
        acc(32'h00A11200, 1'b0, 1'b1, 16'h0, "R9");
        acc(32'h00500000, 1'b0, 1'b1, 16'h0, "R12");
        acc(32'h00500001, 1'b1, 1'b0, 16'h0001, "R12");
        sram_en = 1'b1; sram_alt = 1'b0; sram_start = 24'h200000; sram_end = 24'h200100;
        acc(32'h00200010, 1'b1, 1'b0, 16'h00C3, "R10");
        acc(32'h00200010, 1'b0, 1'b0, 16'h0, "R10");
        sram_alt = 1'b1;
        acc(32'h00200011, 1'b0, 1'b0, 16'h0, "R10");
        acc(32'h00200010, 1'b0, 1'b1, 16'h0, "R10");    // word goes to ROM
        sram_start = 24'hC00000; sram_end = 24'hC00020;
        acc(32'h00C00004, 1'b0, 1'b0, 16'h0, "R11");
        acc(32'h00C00018, 1'b0, 1'b0, 16'h0, "R11");
        sram_start = 24'h300000; sram_end = 24'h300040;

        s = $urandom(32'd5150);
        for (int k = 0; k < 400; k++) begin
            r = $urandom;
            acc({8'h00, bases[r[3:0] % 13] + 24'(r[9:4])}, r[10], r[11], 16'(r[31:16]), "");
        end
        if (s == 32'hFFFFFFFF) $display("seed edge");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule